// File: doc/BRIEF.md
# Selectable Arithmetic Unit

This block is combinational. It takes two unsigned 8-bit operands and a 2-bit operation code, and drives a single 16-bit result bus. Depending on the code, the result is the sum, the product, a comparison flag word, or zero. No operation uses the language's built-in addition, multiplication or relational operators.

The sum comes from two 4-bit carry-lookahead stages in cascade. Each stage computes every internal carry directly from its generate, propagate and carry-in terms. The product comes from a carry-save array of AND gates and full adders, which ends in a ripple row that forms the upper product half. A most-significant-bit-first magnitude comparator produces the comparison flags. A small decoder turns the operation code into one-hot enables, and those enables gate the three paths onto the shared output.

Top module: `sel_arith_unit`

## Requirements
- R1: With opSel = 2'b00 the result holds the 9-bit sum of opA and opB in bits 8:0, with the carry-out in bit 8 and bits 15:9 at zero.
- R2: With opSel = 2'b01 the result is the full 16-bit unsigned product of opA and opB.
- R3: With opSel = 2'b10 the result has bit 0 set when opA > opB, bit 1 set when opA == opB and bit 2 set when opA < opB, compared unsigned. Exactly one of these bits is set, and bits 15:3 are zero.
- R4: With opSel = 2'b11 every bit of the result is zero, whatever the operand values.
- R5: The result follows any change of opA, opB or opSel without waiting for a clock edge.
- R6: A carry that starts in the low nibble reaches the high nibble and the carry-out: 0x0F + 0x01 gives 0x0010, and 0xFF + 0x01 gives 0x0100.
- R7: The product at the extremes is correct: 0 × 0 gives 0x0000, and 255 × 255 gives 0xFE01. A zero operand always gives a zero product.
- R8: The most significant differing bit decides the comparison, so 0x80 against 0x7F reports greater than, and 0x7F against 0x80 reports less than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand |
| opSel | input | 2 | Operation code: 00 add, 01 multiply, 10 compare, 11 zero |
| result | output | 16 | Shared result bus |

## Verification
The embedded checks assume that the operands and the operation code are settled 2-state values whenever they are evaluated. In particular, they assume that no input changes partway through a settling pass. The bench drives every input on the falling edge of its clock and reads the result one time step later. Each combinational evaluation therefore starts from stable, fully defined inputs, and the operation code stays within its four defined encodings.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_MUL  = 2'b01,
    OP_CMP  = 2'b10,
    OP_NONE = 2'b11
  } opCode_e;

  typedef struct packed {
    logic addEn;
    logic mulEn;
    logic cmpEn;
  } pathStrobes_t;
endpackage

// File: rtl/sau_fa.sv
module sau_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/sau_cla4.sv
module sau_cla4 (
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       ci,
  output logic [3:0] s,
  output logic       co
);
  logic [3:0] prop;
  logic [3:0] gen;
  logic [4:0] carry;

  assign prop = x ^ y;
  assign gen  = x & y;

  // Each carry is a flat sum of products over g, p and ci (no ripple).
  always_comb begin
    logic term;
    logic acc;
    carry[0] = ci;
    for (int k = 1; k <= 4; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      term = ci;
      for (int m = 0; m < k; m++) term = term & prop[m];
      carry[k] = acc | term;
    end
  end

  assign s  = prop ^ carry[3:0];
  assign co = carry[4];
endmodule

// File: rtl/sau_adder.sv
module sau_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH:0]   sum
);
  localparam int NIBBLES = WIDTH / 4;

  logic [NIBBLES:0] chain;
  assign chain[0] = 1'b0;

  for (genvar n = 0; n < NIBBLES; n++) begin : g_stage
    sau_cla4 stage_i (
      .x (a[4*n +: 4]),
      .y (b[4*n +: 4]),
      .ci(chain[n]),
      .s (sum[4*n +: 4]),
      .co(chain[n+1])
    );
  end
  assign sum[WIDTH] = chain[NIBBLES];

  always_comb begin
    // R1
    if (a == '0) add_identity_chk: assert (sum == {1'b0, b});
  end
endmodule

// File: rtl/sau_mult.sv
module sau_mult #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] prod
);
  localparam int ROWW = WIDTH - 1;

  logic [WIDTH-1:0][ROWW-1:0] sRow;
  logic [WIDTH-1:0][ROWW-1:0] cRow;
  logic [ROWW:0]              ripple;

  // first row: AND gates only
  assign prod[0] = a[0] & b[0];
  for (genvar j = 0; j < ROWW; j++) begin : g_top
    assign sRow[0][j] = a[0] & b[j+1];
    assign cRow[0][j] = 1'b0;
  end

  // middle rows: carry-save accumulation
  for (genvar i = 1; i < WIDTH; i++) begin : g_row
    assign sRow[i][ROWW-1] = a[i] & b[WIDTH-1];
    for (genvar j = 0; j < ROWW; j++) begin : g_cell
      logic sumBit;
      sau_fa fa_i (
        .x (sRow[i-1][j]),
        .y (cRow[i-1][j]),
        .ci(a[i] & b[j]),
        .s (sumBit),
        .co(cRow[i][j])
      );
      if (j == 0) begin : g_lsb
        assign prod[i] = sumBit;
      end else begin : g_mid
        assign sRow[i][j-1] = sumBit;
      end
    end
  end

  // last row: ripple carry for the upper half
  assign ripple[0] = 1'b0;
  for (genvar j = 0; j < ROWW; j++) begin : g_last
    sau_fa fa_i (
      .x (sRow[WIDTH-1][j]),
      .y (cRow[WIDTH-1][j]),
      .ci(ripple[j]),
      .s (prod[WIDTH+j]),
      .co(ripple[j+1])
    );
  end
  assign prod[2*WIDTH-1] = ripple[ROWW];

  always_comb begin
    // R7
    if ((a == '0) || (b == '0)) mul_zero_chk: assert (prod == '0);
  end
endmodule

// File: rtl/sau_cmp.sv
module sau_cmp #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             gt,
  output logic             eq,
  output logic             lt
);
  always_comb begin
    logic same;
    same = 1'b1;
    gt   = 1'b0;
    lt   = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      gt   = gt | (same & a[i] & ~b[i]);
      lt   = lt | (same & ~a[i] & b[i]);
      same = same & ~(a[i] ^ b[i]);
    end
    eq = same;
  end

  always_comb begin
    // R3
    cmp_one_flag_chk: assert ($countones({gt, eq, lt}) == 1);
    // R3
    if (a == b) cmp_equal_chk: assert (eq);
  end
endmodule

// File: rtl/sau_ctrl.sv
module sau_ctrl
  import sau_pkg::*;
(
  input  logic [1:0]   opSel,
  output pathStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (opSel)
      OP_ADD:  strobes.addEn = 1'b1;
      OP_MUL:  strobes.mulEn = 1'b1;
      OP_CMP:  strobes.cmpEn = 1'b1;
      default: strobes = '0;
    endcase
  end

  always_comb begin
    // R4
    strobe_onehot_chk: assert ($onehot0(strobes));
    // R4
    if (opSel == OP_NONE) strobe_idle_chk: assert (strobes == '0);
  end
endmodule

// File: rtl/sau_datapath.sv
module sau_datapath
  import sau_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  pathStrobes_t       strobes,
  output logic [2*WIDTH-1:0] result
);
  localparam int RW = 2 * WIDTH;

  logic [WIDTH:0]  sumW;
  logic [RW-1:0]   prodW;
  logic            isGt, isEq, isLt;
  logic [RW-1:0]   addExt, cmpExt;

  sau_adder #(.WIDTH(WIDTH)) adder_i (.a(opA), .b(opB), .sum(sumW));
  sau_mult  #(.WIDTH(WIDTH)) mult_i  (.a(opA), .b(opB), .prod(prodW));
  sau_cmp   #(.WIDTH(WIDTH)) cmp_i   (.a(opA), .b(opB), .gt(isGt), .eq(isEq), .lt(isLt));

  assign addExt = {{(RW-WIDTH-1){1'b0}}, sumW};
  assign cmpExt = {{(RW-3){1'b0}}, isLt, isEq, isGt};

  assign result = ({RW{strobes.addEn}} & addExt)
                | ({RW{strobes.mulEn}} & prodW)
                | ({RW{strobes.cmpEn}} & cmpExt);

  always_comb begin
    // R1
    if (strobes.addEn) add_upper_zero_chk: assert (result[RW-1:WIDTH+1] == '0);
    // R3
    if (strobes.cmpEn) cmp_format_chk: assert ((result[RW-1:3] == '0) && ($countones(result[2:0]) == 1));
    // R4
    if (strobes == '0) idle_zero_chk: assert (result == '0);
  end
endmodule

// File: rtl/sel_arith_unit.sv
module sel_arith_unit
  import sau_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [1:0]         opSel,
  output logic [2*WIDTH-1:0] result
);
  pathStrobes_t strobes;

  sau_ctrl ctrl_i (.opSel(opSel), .strobes(strobes));

  sau_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .result (result)
  );
endmodule

// File: tb/sel_arith_unit_tb_top.sv
module sel_arith_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [1:0]  opSel = 2'b11;
  logic [15:0] result;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_arith_unit dut_i (.opA(opA), .opB(opB), .opSel(opSel), .result(result));

  function automatic logic [15:0] refVal(logic [7:0] a, logic [7:0] b, logic [1:0] s);
    case (s)
      2'b00: return 16'(a) + 16'(b);
      2'b01: return 16'(a) * 16'(b);
      2'b10: return {13'b0, (a < b), (a == b), (a > b)};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] a, logic [7:0] b, logic [1:0] s);
    @(negedge clk);
    opA = a; opB = b; opSel = s;
    #1;
  endtask

  task automatic run_op(string tag, logic [7:0] a, logic [7:0] b, logic [1:0] s);
    apply(a, b, s);
    check(tag, result, refVal(a, b, s));
  endtask

  task automatic test_idle_start();
    #1;
    check("R4 initial idle", result, 16'h0000);
  endtask

  task automatic test_add_corners();
    run_op("R1 255+255 carry bit8", 8'hFF, 8'hFF, 2'b00);
    check("R1 255+255 literal", result, 16'h01FE);
    run_op("R6 0F+01", 8'h0F, 8'h01, 2'b00);
    check("R6 0F+01 literal", result, 16'h0010);
    run_op("R6 FF+01", 8'hFF, 8'h01, 2'b00);
    check("R6 FF+01 literal", result, 16'h0100);
  endtask

  task automatic test_mul_corners();
    run_op("R7 0x0", 8'h00, 8'h00, 2'b01);
    run_op("R7 255x255", 8'hFF, 8'hFF, 2'b01);
    check("R7 255x255 literal", result, 16'hFE01);
    run_op("R7 0xA5", 8'h00, 8'hA5, 2'b01);
  endtask

  task automatic test_cmp_corners();
    run_op("R3 equal", 8'h5A, 8'h5A, 2'b10);
    check("R3 equal literal", result, 16'h0002);
    run_op("R8 80 vs 7F", 8'h80, 8'h7F, 2'b10);
    check("R8 80 vs 7F literal", result, 16'h0001);
    run_op("R8 7F vs 80", 8'h7F, 8'h80, 2'b10);
    check("R8 7F vs 80 literal", result, 16'h0004);
  endtask

  task automatic test_zero_select();
    run_op("R4 FFxFF sel11", 8'hFF, 8'hFF, 2'b11);
    run_op("R4 12,34 sel11", 8'h12, 8'h34, 2'b11);
  endtask

  task automatic test_comb_follow();
    // R5: change only the select, then only an operand, without any clock edge
    apply(8'h10, 8'h03, 2'b00);
    opSel = 2'b01; #1;
    check("R5 select change", result, 16'h0030);
    opA = 8'h20; #1;
    check("R5 operand change", result, 16'h0060);
  endtask

  task automatic test_random();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      logic [1:0] s;
      a = 8'($urandom);
      b = 8'($urandom);
      s = 2'(i % 4);
      if (s == 2'b00)      run_op("R1 random add", a, b, s);
      else if (s == 2'b01) run_op("R2 random mul", a, b, s);
      else if (s == 2'b10) run_op("R3 random cmp", a, b, s);
      else                 run_op("R4 random zero", a, b, s);
    end
  endtask

  initial begin
    fork
      begin
        test_idle_start();
        test_add_corners();
        test_mul_corners();
        test_cmp_corners();
        test_zero_select();
        test_comb_follow();
        test_random();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule